// File: doc/BRIEF.md
# Bus Cycle Tracker

This block watches the active-low control strobes of an 8-bit microprocessor bus: machine-cycle-one, read, write, memory request and I/O request. It sorts every sampled bus state into one of seven cycle kinds and follows how that kind changes over time. The strobes, the address bus and the data bus pass through a synchronizer of the same depth, so the three stay aligned with each other.

A move from idle into an active kind marks the start of a bus cycle. The block then reports the captured address. A move from an active kind back to idle marks the end of the cycle. The block then reports the kind that just finished, a data-direction class and the last data byte seen while the cycle was active. A direct move from one active kind to a different active kind is reported as an illegal transition. Each report is a single-cycle pulse. The reports feed a bus monitor or a disassembler further down the chain.

Top module: `bus_cycle_tracker`

## Requirements
- R1: When memory request and read are both low, the kind is opcode fetch (code 5) if machine-cycle-one is low, and memory read (code 1) otherwise.
- R2: When memory request and write are low and read is high, the kind is memory write (code 2).
- R3: I/O request is examined only while memory request is high. With I/O request low, the kind is interrupt acknowledge (code 6) if machine-cycle-one is low. Otherwise it is I/O read (code 3) if read is low, or I/O write (code 4) if write is low.
- R4: A change from idle (code 0) to any active kind raises `cyc_begin` for one cycle, with `cyc_begin_addr` holding the address bus as sampled with that first active state. The pulse appears at the third rising edge after the inputs change (default synchronizer depth of 2).
- R5: A change from an active kind to idle raises `cyc_end` for one cycle. `cyc_end_kind` holds the kind of the finished cycle and `cyc_end_data` holds the data bus value from the last active sample.
- R6: A change from one active kind directly to a different active kind raises `cyc_illegal` for one cycle. No begin or end pulse is issued for that change. At most one of the three pulses is high in any cycle.
- R7: `cyc_end_class` encodes the data direction: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write. An opcode fetch reports 0 and an interrupt acknowledge reports 2.
- R8: While the bus stays in one kind, no further pulses are produced, and no pulse lasts longer than one cycle.
- R9: Synchronous reset `rst` clears all pulses, sets the synchronizer to the idle strobe level and sets the previous kind to idle. A cycle that is active when reset is released therefore yields a begin pulse.
- R10: Bus states that decode to idle produce no pulse. This covers memory request low with neither read nor write low, and both requests high. The data bus value during such states does not reach `cyc_end_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| addr_bus | input | ADDR_W | Address bus |
| data_bus | input | DATA_W | Data bus |
| cyc_begin | output | 1 | Cycle-begin pulse |
| cyc_begin_addr | output | ADDR_W | Address captured at cycle begin |
| cyc_end | output | 1 | Cycle-end pulse |
| cyc_end_kind | output | 3 | Kind of the finished cycle |
| cyc_end_class | output | 2 | Data-direction class of the finished cycle |
| cyc_end_data | output | DATA_W | Last data byte of the finished cycle |
| cyc_illegal | output | 1 | Illegal active-to-active transition pulse |

## Verification
The bench checks the decode priorities directly. One case holds both request strobes low with read low, which must decode as memory read. Another holds I/O request low with machine-cycle-one low and read high, which must decode as interrupt acknowledge. A decoder that checked I/O request first, or ignored machine-cycle-one, would report the wrong kind or class at the end pulse.

The data byte changes partway through an active cycle and again during an idle-decoding state. A design that latched only the first byte, or latched during idle, would report stale or foreign data. A direct jump from a read to an I/O read checks that no spurious begin or end pulse appears and that the next end pulse carries the new kind. A cycle held active across reset release checks that the previous kind restarts at idle.

// File: rtl/bct_pkg.sv
package bct_pkg;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IRD   = 3'd3,
      K_IWR   = 3'd4,
      K_FETCH = 3'd5,
      K_IACK  = 3'd6
   } cyc_kind_e;

   typedef enum logic [1:0] {
      C_MEMRD = 2'd0,
      C_MEMWR = 2'd1,
      C_IORD  = 2'd2,
      C_IOWR  = 2'd3
   } data_class_e;

   typedef struct packed {
      logic m1_n;
      logic rd_n;
      logic wr_n;
      logic mreq_n;
      logic iorq_n;
   } strobes_t;

   localparam int STROBE_W = $bits(strobes_t);

   function automatic data_class_e class_of(cyc_kind_e k);
      case (k)
         K_MWR:          return C_MEMWR;
         K_IRD, K_IACK:  return C_IORD;
         K_IWR:          return C_IOWR;
         default:        return C_MEMRD;
      endcase
   endfunction

endpackage

// File: rtl/bct_sync.sv
module bct_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bct_sync: WIDTH must be at least 1");
      end
      if (STAGES < 0) begin : g_bad_stages
         $error("bct_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] st [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bct_classify.sv
module bct_classify
   import bct_pkg::*;
(
   input  strobes_t  s,
   output cyc_kind_e kind
);

   always_comb begin
      kind = K_NONE;
      if (!s.mreq_n) begin
         if (!s.rd_n)      kind = s.m1_n ? K_MRD : K_FETCH;
         else if (!s.wr_n) kind = K_MWR;
      end else if (!s.iorq_n) begin
         if (!s.m1_n)      kind = K_IACK;
         else if (!s.rd_n) kind = K_IRD;
         else if (!s.wr_n) kind = K_IWR;
      end
   end

endmodule

// File: rtl/bct_tracker.sv
module bct_tracker
   import bct_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  cyc_kind_e         kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              begin_p,
   output logic [ADDR_W-1:0] begin_addr,
   output logic              end_p,
   output cyc_kind_e         end_kind,
   output data_class_e       end_class,
   output logic [DATA_W-1:0] end_data,
   output logic              illegal_p
);

   cyc_kind_e         prev_kind;
   logic [DATA_W-1:0] data_hold;
   logic              changed, from_idle, to_idle;

   assign changed   = (kind != prev_kind);
   assign from_idle = (prev_kind == K_NONE);
   assign to_idle   = (kind == K_NONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_kind  <= K_NONE;
         data_hold  <= '0;
         begin_p    <= 1'b0;
         begin_addr <= '0;
         end_p      <= 1'b0;
         end_kind   <= K_NONE;
         end_class  <= C_MEMRD;
         end_data   <= '0;
         illegal_p  <= 1'b0;
      end else begin
         prev_kind <= kind;
         begin_p   <= changed && from_idle;
         end_p     <= changed && to_idle;
         illegal_p <= changed && !from_idle && !to_idle;
         if (!to_idle) data_hold <= data;
         if (changed && from_idle) begin_addr <= addr;
         if (changed && to_idle) begin
            end_kind  <= prev_kind;
            end_class <= class_of(prev_kind);
            end_data  <= data_hold;
         end
      end
   end

endmodule

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker
   import bct_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              m1_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic [ADDR_W-1:0] addr_bus,
   input  logic [DATA_W-1:0] data_bus,
   output logic              cyc_begin,
   output logic [ADDR_W-1:0] cyc_begin_addr,
   output logic              cyc_end,
   output logic [2:0]        cyc_end_kind,
   output logic [1:0]        cyc_end_class,
   output logic [DATA_W-1:0] cyc_end_data,
   output logic              cyc_illegal
);

   localparam int BUS_W = ADDR_W + DATA_W;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("bus_cycle_tracker: bus widths must be at least 1");
      end
   endgenerate

   strobes_t          raw_s, sync_s;
   logic [BUS_W-1:0]  raw_bus, sync_bus;
   cyc_kind_e         cur_kind, end_kind_e;
   data_class_e       end_class_e;

   assign raw_s   = '{m1_n: m1_n, rd_n: rd_n, wr_n: wr_n,
                      mreq_n: mreq_n, iorq_n: iorq_n};
   assign raw_bus = {addr_bus, data_bus};

   bct_sync #(.WIDTH(STROBE_W), .STAGES(SYNC_STAGES),
              .RST_VAL({STROBE_W{1'b1}})) u_sync_strb (
      .clk(clk), .rst(rst), .d(raw_s), .q(sync_s));

   bct_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES),
              .RST_VAL({BUS_W{1'b0}})) u_sync_bus (
      .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus));

   bct_classify u_cls (.s(sync_s), .kind(cur_kind));

   bct_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
      .clk(clk), .rst(rst), .kind(cur_kind),
      .addr(sync_bus[BUS_W-1:DATA_W]), .data(sync_bus[DATA_W-1:0]),
      .begin_p(cyc_begin), .begin_addr(cyc_begin_addr),
      .end_p(cyc_end), .end_kind(end_kind_e), .end_class(end_class_e),
      .end_data(cyc_end_data), .illegal_p(cyc_illegal));

   assign cyc_end_kind  = end_kind_e;
   assign cyc_end_class = end_class_e;

endmodule

// File: rtl/bct_checker.sv
module bct_checker (
   input logic       clk,
   input logic       rst,
   input logic       b_p,
   input logic       e_p,
   input logic       i_p,
   input logic [2:0] e_kind,
   input logic [1:0] e_class
);

   // R6
   pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({b_p, e_p, i_p}));

   // R8
   begin_single_chk: assert property (@(posedge clk) disable iff (rst)
      b_p |=> !b_p);

   // R8
   end_single_chk: assert property (@(posedge clk) disable iff (rst)
      e_p |=> !e_p);

   // R5
   end_kind_active_chk: assert property (@(posedge clk) disable iff (rst)
      e_p |-> (e_kind != 3'd0 && e_kind <= 3'd6));

   // R7
   fetch_class_chk: assert property (@(posedge clk) disable iff (rst)
      (e_p && e_kind == 3'd5) |-> e_class == 2'd0);

   // R7
   iack_class_chk: assert property (@(posedge clk) disable iff (rst)
      (e_p && e_kind == 3'd6) |-> e_class == 2'd2);

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (!b_p && !e_p && !i_p));

endmodule

bind bus_cycle_tracker bct_checker u_bct_chk (
   .clk(clk), .rst(rst), .b_p(cyc_begin), .e_p(cyc_end),
   .i_p(cyc_illegal), .e_kind(cyc_end_kind), .e_class(cyc_end_class));

// File: tb/bus_cycle_tracker_bench.sv
module bus_cycle_tracker_bench;

   typedef struct {
      int          ev;      // 0 begin, 1 end, 2 illegal
      logic [15:0] addr;
      logic [2:0]  kind;
      logic [1:0]  cls;
      logic [7:0]  data;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
   logic [15:0] addr_bus = '0;
   logic [7:0]  data_bus = '0;
   logic        cyc_begin, cyc_end, cyc_illegal;
   logic [15:0] cyc_begin_addr;
   logic [2:0]  cyc_end_kind;
   logic [1:0]  cyc_end_class;
   logic [7:0]  cyc_end_data;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];
   logic [2:0] m_prev = 3'd0;
   logic [7:0] m_data = '0;
   logic       done = 1'b0;

   always #4 clk = ~clk;

   bus_cycle_tracker u_bus_cycle_tracker (
      .clk(clk), .rst(rst), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .addr_bus(addr_bus), .data_bus(data_bus),
      .cyc_begin(cyc_begin), .cyc_begin_addr(cyc_begin_addr), .cyc_end(cyc_end),
      .cyc_end_kind(cyc_end_kind), .cyc_end_class(cyc_end_class),
      .cyc_end_data(cyc_end_data), .cyc_illegal(cyc_illegal));

   function automatic logic [2:0] kind_of(logic m1, logic rd, logic wr, logic mq, logic io);
      if (!mq) return !rd ? (m1 ? 3'd1 : 3'd5) : (!wr ? 3'd2 : 3'd0);
      if (!io) return !m1 ? 3'd6 : (!rd ? 3'd3 : (!wr ? 3'd4 : 3'd0));
      return 3'd0;
   endfunction

   function automatic logic [1:0] cls_of(logic [2:0] k);
      case (k)
         3'd2:       return 2'd1;
         3'd3, 3'd6: return 2'd2;
         3'd4:       return 2'd3;
         default:    return 2'd0;
      endcase
   endfunction

   function automatic string req_of(logic [2:0] k);
      case (k)
         3'd1, 3'd5: return "R1";
         3'd2:       return "R2";
         default:    return "R3";
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver: applies a bus state and pushes the events the model predicts
   task automatic drive(logic m1, logic rd, logic wr, logic mq, logic io,
                        logic [15:0] a, logic [7:0] d, int hold);
      logic [2:0] k;
      exp_t e;
      @(negedge clk);
      m1_n = m1; rd_n = rd; wr_n = wr; mreq_n = mq; iorq_n = io;
      addr_bus = a; data_bus = d;
      k = kind_of(m1, rd, wr, mq, io);
      if (!rst && k != m_prev) begin
         e = '{ev: 0, addr: a, kind: 3'd0, cls: 2'd0, data: 8'd0};
         if (m_prev == 3'd0) e.ev = 0;
         else if (k == 3'd0) begin
            e.ev = 1; e.kind = m_prev; e.cls = cls_of(m_prev); e.data = m_data;
         end else e.ev = 2;
         q.push_back(e);
      end
      if (k != 3'd0) m_data = d;
      m_prev = rst ? 3'd0 : k;
      repeat (hold - 1) @(negedge clk);
   endtask

   task automatic idle(int hold);
      drive(1, 1, 1, 1, 1, 16'h0000, 8'h00, hold);
   endtask

   // monitor: pops expected events as pulses appear
   always @(negedge clk) begin
      if (!rst && !done && (cyc_begin || cyc_end || cyc_illegal)) begin
         if (q.size() == 0) begin
            check(0, "R10", "unexpected pulse", {cyc_begin, cyc_end, cyc_illegal}, 0);
         end else begin
            automatic exp_t e = q.pop_front();
            if (e.ev == 0) begin
               check(cyc_begin, "R4", "begin pulse", cyc_begin, 1);
               check(cyc_begin_addr == e.addr, "R4", "begin addr", cyc_begin_addr, e.addr);
            end else if (e.ev == 1) begin
               check(cyc_end, "R5", "end pulse", cyc_end, 1);
               check(cyc_end_kind == e.kind, req_of(e.kind), "end kind", cyc_end_kind, e.kind);
               check(cyc_end_class == e.cls, "R7", "end class", cyc_end_class, e.cls);
               check(cyc_end_data == e.data, "R5", "end data", cyc_end_data, e.data);
            end else begin
               check(cyc_illegal && !cyc_begin && !cyc_end, "R6", "illegal pulse",
                     {cyc_begin, cyc_end, cyc_illegal}, 1);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      check(!cyc_begin && !cyc_end && !cyc_illegal, "R9", "pulses in reset",
            {cyc_begin, cyc_end, cyc_illegal}, 0);
      rst = 1'b0;
      idle(4);
      // R4 latency: begin pulse at third rising edge after change
      @(negedge clk);
      m1_n = 1; rd_n = 0; wr_n = 1; mreq_n = 0; iorq_n = 1;
      addr_bus = 16'h1234; data_bus = 8'h5A;
      q.push_back('{ev: 0, addr: 16'h1234, kind: 3'd0, cls: 2'd0, data: 8'd0});
      m_prev = 3'd1; m_data = 8'h5A;
      @(negedge clk); @(negedge clk);
      check(!cyc_begin, "R4", "begin too early", cyc_begin, 0);
      @(negedge clk);
      repeat (2) @(negedge clk);
      // R5: data changes mid-cycle, last value reported
      drive(1, 0, 1, 0, 1, 16'h1234, 8'hA5, 3);
      idle(4);
      drive(0, 0, 1, 0, 1, 16'h0100, 8'h3E, 3);   // R1 fetch
      idle(4);
      drive(1, 1, 0, 0, 1, 16'h8001, 8'h77, 3);   // R2 memory write
      idle(4);
      drive(1, 0, 1, 1, 0, 16'h00FE, 8'h19, 3);   // R3 io read
      idle(4);
      drive(1, 1, 0, 1, 0, 16'h0042, 8'hC3, 3);   // R3 io write
      idle(4);
      drive(0, 1, 1, 1, 0, 16'h0000, 8'hFF, 3);   // R3 interrupt ack
      idle(4);
      drive(1, 0, 1, 0, 0, 16'h2222, 8'h61, 3);   // R3 io request ignored with mreq low
      idle(4);
      // R10: idle-decoding states with changing data
      drive(1, 1, 1, 0, 1, 16'h3333, 8'hEE, 3);
      drive(1, 1, 1, 0, 0, 16'h3334, 8'hDD, 3);
      idle(4);
      drive(1, 1, 0, 0, 1, 16'h4444, 8'h12, 3);
      drive(1, 1, 1, 0, 1, 16'h4444, 8'h99, 3);   // R10 data here must not be reported
      idle(4);
      // R6: direct active to active
      drive(1, 0, 1, 0, 1, 16'h5000, 8'h01, 3);
      drive(1, 0, 1, 1, 0, 16'h5001, 8'h02, 5);   // R8 held, no extra pulses
      idle(4);
      // R9: cycle active across reset release
      repeat (6) @(negedge clk);
      rst = 1'b1;
      drive(1, 1, 0, 0, 1, 16'h6060, 8'h44, 4);
      @(negedge clk);
      rst = 1'b0;
      q.push_back('{ev: 0, addr: 16'h6060, kind: 3'd0, cls: 2'd0, data: 8'd0});
      m_prev = 3'd2; m_data = 8'h44;
      repeat (4) @(negedge clk);
      idle(8);
      check(q.size() == 0, "R8", "events left over", q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule